// File: doc/BRIEF.md
# Expansion RAM Bank Mapper

The block sits beside an 8-bit CPU with a 64K address space and decides, on every bus cycle, whether the access goes to the main memory side or to a second 64K RAM bank. A write-only control byte, loaded by any CPU write to the fixed address `CTRL_ADDR` (default $FFF0), enables the bank. It picks which 16K quarter of the bank shows through each of two windows in the upper half of the address space, and it can write-protect either window. It can also punch two holes through the windows: one for the I/O page and one for the first 4K of screen memory.

The outputs are combinational in the current address and the stored control byte. The control byte changes on the clock edge that ends the writing cycle, so the writing cycle itself is still routed with the old mapping. The expansion address is a 16-bit offset into the bank: a 2-bit block number above address bits 13:0.

Control byte fields (bit: meaning when 1): 7 bank enable; 6 I/O hole at $E800-$EFFF; 5 screen hole at $8000-$8FFF; 4 reserved; 3 upper window shows block 3 (else block 2); 2 lower window shows block 1 (else block 0); 1 write-protect upper window; 0 write-protect lower window.

Top module: `xbank_mapper`

## Requirements
- R1: While rst_ni is low and after its release, until a control write, the control byte is zero: main_sel_o=1, xsel_o=0, xwe_o=0, xaddr_o=0 for every address.
- R2: A cycle with we_i=1 and addr_i=CTRL_ADDR loads data_i into the control byte at the end of that cycle. That cycle is still routed with the previous byte. A read of CTRL_ADDR changes nothing.
- R3: Addresses $0000-$7FFF always give main_sel_o=1 and xsel_o=0.
- R4: With bit 7 clear, every address gives main_sel_o=1 and xsel_o=0.
- R5: With bit 7 set, $8000-$BFFF (outside a hole) gives xsel_o=1 and xaddr_o = {1'b0, bit2, addr_i[13:0]}.
- R6: With bit 7 set, $C000-$FFFF (outside a hole) gives xsel_o=1 and xaddr_o = {1'b1, bit3, addr_i[13:0]}.
- R7: With bits 7 and 6 set, $E800-$EFFF gives main_sel_o=1, xsel_o=0, xwe_o=0, even with bit 1 set.
- R8: With bits 7 and 5 set, $8000-$8FFF gives main_sel_o=1, xsel_o=0, xwe_o=0, even with bit 0 set. $9000-$BFFF is still expansion.
- R9: Bit 0 holds xwe_o low for writes to the lower window, while xsel_o stays 1 for reads and writes there.
- R10: Bit 1 holds xwe_o low for writes to the upper window, while xsel_o stays 1 there.
- R11: Bit 4 has no effect on any output.
- R12: Exactly one of xsel_o and main_sel_o is high in every cycle. xaddr_o is zero whenever xsel_o is 0.
- R13: xwe_o is high only when we_i=1, xsel_o=1 and the window of the address is not protected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| we_i | input | 1 | 1 = write cycle, 0 = read cycle |
| xaddr_o | output | 16 | Offset into the expansion bank |
| xsel_o | output | 1 | Access goes to expansion RAM |
| xwe_o | output | 1 | Write strobe to expansion RAM |
| main_sel_o | output | 1 | Access goes to the main side |

## Verification
Every routing output is due in the same cycle as its address, with no register in the path. A control write takes effect on the cycle after its clock edge. The bench therefore drives each bus cycle on the falling edge and compares all four outputs two nanoseconds later, against a reference model. The model's control byte updates only on the rising edge, so the check of a writing cycle always sees the old mapping and the following check sees the new one. Directed cycles cover each field and hole boundary, and a long pseudo-random run mixes control writes with accesses.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int WIN_W   = ADDR_W - 2;
  localparam int BLK_W   = 2;

  // field order follows the software-visible bit positions 7..0
  typedef struct packed {
    logic en;
    logic io_hole;
    logic scr_hole;
    logic rsvd;
    logic sel_hi;
    logic sel_lo;
    logic wp_hi;
    logic wp_lo;
  } ctrl_t;

  typedef struct packed {
    logic exp_region;
    logic win_hi;
    logic hole;
  } region_t;
endpackage

// File: rtl/xbm_ctrl_reg.sv
module xbm_ctrl_reg
  import xbm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              we_i,
  output ctrl_t             ctrl_o
);
  logic  hit;
  ctrl_t ctrl_q;

  assign hit = we_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (hit) ctrl_q <= ctrl_t'(data_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/xbm_region_decode.sv
module xbm_region_decode
  import xbm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] IO_FIRST  = 16'hE800,
  parameter logic [ADDR_W-1:0] IO_LAST   = 16'hEFFF,
  parameter logic [ADDR_W-1:0] SCR_FIRST = 16'h8000,
  parameter logic [ADDR_W-1:0] SCR_LAST  = 16'h8FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  output region_t           region_o
);
  logic in_io, in_scr;

  assign in_io  = (addr_i >= IO_FIRST)  && (addr_i <= IO_LAST);
  assign in_scr = (addr_i >= SCR_FIRST) && (addr_i <= SCR_LAST);

  always_comb begin
    region_o.exp_region = ctrl_i.en && addr_i[ADDR_W-1];
    region_o.win_hi     = addr_i[ADDR_W-2];
    region_o.hole       = (ctrl_i.io_hole && in_io) || (ctrl_i.scr_hole && in_scr);
  end
endmodule

// File: rtl/xbm_route.sv
module xbm_route
  import xbm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  ctrl_t             ctrl_i,
  input  region_t           region_i,
  output logic [ADDR_W-1:0] xaddr_o,
  output logic              xsel_o,
  output logic              xwe_o
);
  logic [BLK_W-1:0] blk;
  logic             prot;

  always_comb begin
    xsel_o  = region_i.exp_region && !region_i.hole;
    blk     = region_i.win_hi ? {1'b1, ctrl_i.sel_hi} : {1'b0, ctrl_i.sel_lo};
    prot    = region_i.win_hi ? ctrl_i.wp_hi : ctrl_i.wp_lo;
    xaddr_o = xsel_o ? {blk, addr_i[WIN_W-1:0]} : '0;
    xwe_o   = xsel_o && we_i && !prot;
  end
endmodule

// File: rtl/xbank_mapper.sv
module xbank_mapper
  import xbm_pkg::*;
#(
  parameter logic [15:0] CTRL_ADDR = 16'hFFF0,
  parameter logic [15:0] IO_FIRST  = 16'hE800,
  parameter logic [15:0] IO_LAST   = 16'hEFFF,
  parameter logic [15:0] SCR_FIRST = 16'h8000,
  parameter logic [15:0] SCR_LAST  = 16'h8FFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        we_i,
  output logic [15:0] xaddr_o,
  output logic        xsel_o,
  output logic        xwe_o,
  output logic        main_sel_o
);
  ctrl_t   ctrl;
  region_t region;

  xbm_ctrl_reg #(.CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .data_i (data_i),
    .we_i   (we_i),
    .ctrl_o (ctrl)
  );

  xbm_region_decode #(
    .IO_FIRST (IO_FIRST),
    .IO_LAST  (IO_LAST),
    .SCR_FIRST(SCR_FIRST),
    .SCR_LAST (SCR_LAST)
  ) u_dec (
    .addr_i   (addr_i),
    .ctrl_i   (ctrl),
    .region_o (region)
  );

  xbm_route u_route (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .ctrl_i   (ctrl),
    .region_i (region),
    .xaddr_o  (xaddr_o),
    .xsel_o   (xsel_o),
    .xwe_o    (xwe_o)
  );

  assign main_sel_o = !xsel_o;
endmodule

// File: rtl/xbank_mapper_chk.sv
module xbank_mapper_chk #(
  parameter logic [15:0] CTRL_ADDR = 16'hFFF0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        we_i,
  input logic [15:0] xaddr_o,
  input logic        xsel_o,
  input logic        xwe_o,
  input logic        main_sel_o
);
  logic ctl_loaded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_loaded <= 1'b0;
    else if (we_i && addr_i == CTRL_ADDR) ctl_loaded <= 1'b1;
  end

  a_r12_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xsel_o != main_sel_o);

  a_r12_addr_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xsel_o |-> xaddr_o == 16'h0);

  a_r3_low_half_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[15] |-> main_sel_o);

  a_r13_xwe_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xwe_o |-> (we_i && xsel_o));

  a_r1_main_until_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_loaded |-> (main_sel_o && !xwe_o));

  a_r5_lower_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xsel_o && !addr_i[14]) |-> (!xaddr_o[15] && xaddr_o[13:0] == addr_i[13:0]));

  a_r6_upper_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xsel_o && addr_i[14]) |-> (xaddr_o[15] && xaddr_o[13:0] == addr_i[13:0]));
endmodule

bind xbank_mapper xbank_mapper_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .xaddr_o    (xaddr_o),
  .xsel_o     (xsel_o),
  .xwe_o      (xwe_o),
  .main_sel_o (main_sel_o)
);

// File: tb/xbank_mapper_test.sv
module xbank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  data = 8'h0;
  logic        we = 1'b0;
  logic [15:0] xaddr;
  logic        xsel, xwe, msel;

  int vectors = 0;
  int miscompares = 0;
  int mreg = 0;

  always #4 clk = ~clk;

  xbank_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .we_i(we),
    .xaddr_o(xaddr), .xsel_o(xsel), .xwe_o(xwe), .main_sel_o(msel)
  );

  // reference control byte
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreg <= 0;
    else if (we && addr == 16'hFFF0) mreg <= int'(data);
  end

  task automatic check(input string tag);
    int a, ex_xa, blk;
    bit ex_sel, ex_we, prot;
    a = int'(addr);
    ex_sel = 0; ex_we = 0; ex_xa = 0;
    if (a >= 'h8000 && mreg[7]) begin
      ex_sel = 1;
      if (mreg[6] && a >= 'hE800 && a <= 'hEFFF) ex_sel = 0;
      if (mreg[5] && a < 'h9000) ex_sel = 0;
    end
    if (ex_sel) begin
      if (a >= 'hC000) begin blk = 2 + mreg[3]; prot = mreg[1]; end
      else begin blk = mreg[2]; prot = mreg[0]; end
      ex_xa = blk * 16384 + (a % 16384);
      ex_we = we && !prot;
    end
    vectors++;
    if (xsel !== ex_sel || msel !== !ex_sel || xwe !== ex_we || int'(xaddr) != ex_xa) begin
      miscompares++;
      $display("FAIL %s addr=%h we=%0d ctl=%h: got sel=%b main=%b we=%b xa=%h exp sel=%b main=%b we=%b xa=%h",
               tag, addr, we, mreg[7:0], xsel, msel, xwe, xaddr, ex_sel, !ex_sel, ex_we, ex_xa[15:0]);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic w, input logic [7:0] d, input string tag);
    @(negedge clk);
    addr = a; we = w; data = d;
    #2 check(tag);
  endtask

  task automatic ctl(input logic [7:0] d, input string tag);
    cyc(16'hFFF0, 1'b1, d, tag);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state, including a control write during reset
    @(negedge clk); addr = 16'hA000; #2 check("R1");
    @(negedge clk); addr = 16'hFFF0; we = 1; data = 8'h80; #2 check("R1");
    @(negedge clk); we = 0; rst_n = 1'b1;
    cyc(16'hC000, 1'b1, 8'h00, "R1");
    cyc(16'hFFFF, 1'b0, 8'h00, "R1");

    // R4: bank disabled, other fields set
    ctl(8'h7F, "R4");
    cyc(16'hA000, 1'b1, 8'h00, "R4");
    cyc(16'hD123, 1'b0, 8'h00, "R4");

    // R2: read of the control address with enable on the data lines
    cyc(16'hFFF0, 1'b0, 8'h80, "R2");
    cyc(16'hA000, 1'b0, 8'h00, "R2");
    // R2: writing cycle uses old mapping, next one the new
    ctl(8'h80, "R2");
    cyc(16'h8123, 1'b0, 8'h00, "R5");
    cyc(16'hC456, 1'b1, 8'h00, "R6");
    cyc(16'hBFFF, 1'b1, 8'h00, "R5");
    cyc(16'h7FFF, 1'b1, 8'h00, "R3");
    cyc(16'h1234, 1'b0, 8'h00, "R3");

    ctl(8'h8C, "R2");
    cyc(16'h8123, 1'b1, 8'h00, "R5");
    cyc(16'hC456, 1'b0, 8'h00, "R6");
    cyc(16'hFFF0, 1'b1, 8'h8C, "R6");   // control write while mapped
    cyc(16'hFFFF, 1'b1, 8'h00, "R6");

    // R9 / R10 write protection
    ctl(8'h81, "R9");
    cyc(16'h9000, 1'b1, 8'h00, "R9");
    cyc(16'h9000, 1'b0, 8'h00, "R9");
    cyc(16'hD000, 1'b1, 8'h00, "R9");
    ctl(8'h82, "R10");
    cyc(16'hD000, 1'b1, 8'h00, "R10");
    cyc(16'hD000, 1'b0, 8'h00, "R10");
    cyc(16'h9000, 1'b1, 8'h00, "R10");

    // R8 screen hole overrides lower protection
    ctl(8'hA3, "R8");
    cyc(16'h8000, 1'b1, 8'h00, "R8");
    cyc(16'h8FFF, 1'b1, 8'h00, "R8");
    cyc(16'h9000, 1'b1, 8'h00, "R8");
    cyc(16'hE900, 1'b1, 8'h00, "R8");

    // R7 I/O hole overrides upper protection
    ctl(8'hC3, "R7");
    cyc(16'hE800, 1'b1, 8'h00, "R7");
    cyc(16'hEFFF, 1'b0, 8'h00, "R7");
    cyc(16'hE7FF, 1'b0, 8'h00, "R7");
    cyc(16'hF000, 1'b1, 8'h00, "R7");
    cyc(16'h8000, 1'b0, 8'h00, "R7");

    // R11 reserved bit
    ctl(8'h94, "R11");
    cyc(16'h8ABC, 1'b1, 8'h00, "R11");
    cyc(16'hCABC, 1'b1, 8'h00, "R11");
    cyc(16'hE900, 1'b1, 8'h00, "R11");

    // R13 reads never strobe
    ctl(8'h80, "R13");
    cyc(16'hA555, 1'b0, 8'h00, "R13");
    cyc(16'hA555, 1'b1, 8'h00, "R13");

    // R12 mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic        w;
      a = 16'($urandom);
      d = 8'($urandom);
      w = 1'($urandom);
      if ((i % 9) == 0) begin a = 16'hFFF0; end
      else if ((i % 3) != 0) a[15] = 1'b1;
      cyc(a, w, d, "R12");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule